// File: doc/BRIEF.md
# Program Memory Bank Mapper

This block translates a processor address inside a 32 KiB program window into an 8 KiB bank number and an offset within that bank. The bank number points into a large program memory. A twelve-bit outer base sets where in that memory the window lands. The base is gathered from fields spread over three configuration bytes. A three-bit layout code in the control byte chooses how the window is split:

- one 32 KiB region;
- one 16 KiB region that appears in both halves of the window;
- four 8 KiB slots, each filled from an inner bank byte.

In the slot layouts, a narrowing inner mask decides how many low bank bits the inner bytes supply and how many come from the base. An extended flag switches the slots to four independent inner bytes that are not masked. A swap flag exchanges the first and third slots.

Lookups flow through a one-deep valid/ready stage. A lookup is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new lookup is taken.

The configuration and inner bytes are plain control inputs. They are sampled on the edge that takes the lookup.

Top module: `prg_bank_mapper`

## Requirements
- R1: The outer base B (12 bits) is {hi[5], hi[7], hi[6], ctrl[7], ctrl[3], lo[6:0]}, most significant bit first. Here ctrl is `cfg_ctrl`, lo is `cfg_outer_lo` and hi is `cfg_outer_hi`.
- R2: When the layout code ctrl[2:0] is 4, 5, 6 or 7, the bank is {B[11:1], addr[14:13]}.
- R3: When the layout code is 3, the bank is {B, addr[13]}. addr[14] has no effect, so both 16 KiB halves reach the same region.
- R4: For layout codes 0, 1 and 2 with the extended flag low, let M = 0x3F >> code and O = B<<1. Slot s = addr[14:13] yields (v & M) | (O & ~M), where v is `inner_a` for slot 0, `inner_b` for slot 1, 0xFE for slot 2 and 0xFF for slot 3.
- R5: For layout codes 0 to 2 with `swap_en` high, slot 0 takes the value listed for slot 2 and slot 2 takes the value listed for slot 0. Slots 1 and 3 are unchanged.
- R6: For layout codes 0 to 2 with `ext_en` high, slot s yields v | O, with no mask. v is `inner_a`, `inner_b`, `inner_c` and `inner_d` for slots 0 to 3, and the swap of R5 still applies.
- R7: For layout codes 3 to 7, `swap_en` and `ext_en` have no effect on the bank.
- R8: `out_offset` equals addr[12:0] of the lookup that was taken.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A taken lookup shows `out_valid` high on the next cycle. While the output is stalled, `out_bank` and `out_offset` stay stable.
- R10: While `rst_n` is low and after its release, `out_valid` is low until a lookup is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctrl | input | 8 | Control byte: layout code in [2:0], base bits in [3] and [7] |
| cfg_outer_lo | input | 8 | Low base field in [6:0] |
| cfg_outer_hi | input | 8 | High base fields in [7:5] |
| inner_a | input | 8 | Inner bank byte for slot 0 |
| inner_b | input | 8 | Inner bank byte for slot 1 |
| inner_c | input | 8 | Extended-mode byte for slot 2 |
| inner_d | input | 8 | Extended-mode byte for slot 3 |
| swap_en | input | 1 | Exchange slots 0 and 2 in the slot layouts |
| ext_en | input | 1 | Unmasked four-byte slot filling |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Lookup request accepted when high |
| in_addr | input | 15 | Address within the 32 KiB window |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_bank | output | 13 | 8 KiB bank number |
| out_offset | output | 13 | Offset within the 8 KiB bank |

## Verification
The bench drives every layout code with every slot, for both swap and extended settings. This catches the following faults:

- A design that treats codes 5 to 7 as undefined returns a wrong bank.
- A design that lets the mask narrow in the wrong direction takes the wrong number of bank bits from the base.
- A design that applies swap or extended outside the slot layouts changes a bank that must stay fixed.

A directed lookup with a base containing every scattered field bit exposes a field wired to the wrong bit. Random back-pressure with inputs that change during a stall shows a result that is overwritten, or a lookup that is dropped or duplicated.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  // Width of the assembled outer base and of the resulting 8 KiB bank number.
  localparam int BASE_W = 12;
  localparam int BANK_W = BASE_W + 1;

  typedef enum logic [1:0] {
    LAY_SLOTS = 2'd0,  // four 8 KiB slots
    LAY_HALF  = 2'd1,  // one 16 KiB region mirrored in both halves
    LAY_WHOLE = 2'd2   // one 32 KiB region
  } layout_e;

  function automatic layout_e layout_of(input logic [2:0] code);
    layout_e lay;
    case (code)
      3'd0, 3'd1, 3'd2: lay = LAY_SLOTS;
      3'd3:             lay = LAY_HALF;
      default:          lay = LAY_WHOLE;
    endcase
    return lay;
  endfunction

endpackage

// File: rtl/prg_outer_base.sv
module prg_outer_base
  import prg_map_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic [REG_W-1:0]  ctrl_i,
  input  logic [REG_W-1:0]  lo_i,
  input  logic [REG_W-1:0]  hi_i,
  output logic [BASE_W-1:0] base_o
);

  localparam int LO_W = 7;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{ctrl_i, lo_i, hi_i};

  // Gather the scattered base fields into one contiguous value.
  always_comb begin
    base_o             = '0;
    base_o[LO_W-1:0]   = lo_i[LO_W-1:0];
    base_o[7]          = ctrl_i[3];
    base_o[8]          = ctrl_i[7];
    base_o[10:9]       = hi_i[7:6];
    base_o[11]         = hi_i[5];
  end

endmodule

// File: rtl/prg_slot_map.sv
module prg_slot_map
  import prg_map_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int SLOT_BITS = 2
) (
  input  logic [2:0]           mode_i,
  input  logic [BASE_W-1:0]    base_i,
  input  logic [REG_W-1:0]     inner_a_i,
  input  logic [REG_W-1:0]     inner_b_i,
  input  logic [REG_W-1:0]     inner_c_i,
  input  logic [REG_W-1:0]     inner_d_i,
  input  logic                 swap_i,
  input  logic                 ext_i,
  input  logic [SLOT_BITS-1:0] slot_i,
  output logic [BANK_W-1:0]    bank_o
);

  localparam int SLOTS  = 1 << SLOT_BITS;
  localparam int MASK_W = 6;
  localparam int PAD_W  = BANK_W - REG_W;

  layout_e            lay;
  logic [BANK_W-1:0]  outer_x2;
  logic [BANK_W-1:0]  inner_mask;
  logic [REG_W-1:0]   src [SLOTS];
  logic [BANK_W-1:0]  slot_bank [SLOTS];

  assign lay        = layout_of(mode_i);
  assign outer_x2   = {base_i, 1'b0};
  assign inner_mask = {{(BANK_W-MASK_W){1'b0}}, ({MASK_W{1'b1}} >> mode_i[1:0])};

  // Logical sources before the swap is applied.
  always_comb begin
    src[0] = inner_a_i;
    src[1] = inner_b_i;
    src[2] = ext_i ? inner_c_i : {{(REG_W-1){1'b1}}, 1'b0};
    src[3] = ext_i ? inner_d_i : {REG_W{1'b1}};
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    // Even slots swap with their partner two slots away.
    localparam int ALT = ((s % 2) == 0) ? (s ^ 2) : s;
    logic [REG_W-1:0]  pick;
    logic [BANK_W-1:0] wide;
    assign pick = swap_i ? src[ALT] : src[s];
    assign wide = {{PAD_W{1'b0}}, pick};
    assign slot_bank[s] = ext_i ? (wide | outer_x2)
                                : ((wide & inner_mask) | (outer_x2 & ~inner_mask));
  end

  always_comb begin
    case (lay)
      LAY_SLOTS: bank_o = slot_bank[slot_i];
      LAY_HALF:  bank_o = {base_i, slot_i[0]};
      default:   bank_o = {base_i[BASE_W-1:1], slot_i};
    endcase
  end

endmodule

// File: rtl/prg_xfer_stage.sv
module prg_xfer_stage #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

  AST_TAKEN_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9

  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid); // R10

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int OFS_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  cfg_ctrl,
  input  logic [REG_W-1:0]  cfg_outer_lo,
  input  logic [REG_W-1:0]  cfg_outer_hi,
  input  logic [REG_W-1:0]  inner_a,
  input  logic [REG_W-1:0]  inner_b,
  input  logic [REG_W-1:0]  inner_c,
  input  logic [REG_W-1:0]  inner_d,
  input  logic              swap_en,
  input  logic              ext_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OFS_W+1:0]  in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BANK_W-1:0] out_bank,
  output logic [OFS_W-1:0]  out_offset
);

  localparam int SLOT_BITS = 2;
  localparam int WIN_W     = OFS_W + SLOT_BITS;
  localparam int PKT_W     = BANK_W + OFS_W;

  logic [BASE_W-1:0] outer;
  logic [BANK_W-1:0] bank_c;
  logic [PKT_W-1:0]  pkt_out;
  logic              taken;

  prg_outer_base #(.REG_W(REG_W)) u_base (
    .ctrl_i (cfg_ctrl),
    .lo_i   (cfg_outer_lo),
    .hi_i   (cfg_outer_hi),
    .base_o (outer)
  );

  prg_slot_map #(.REG_W(REG_W), .SLOT_BITS(SLOT_BITS)) u_map (
    .mode_i    (cfg_ctrl[2:0]),
    .base_i    (outer),
    .inner_a_i (inner_a),
    .inner_b_i (inner_b),
    .inner_c_i (inner_c),
    .inner_d_i (inner_d),
    .swap_i    (swap_en),
    .ext_i     (ext_en),
    .slot_i    (in_addr[WIN_W-1:OFS_W]),
    .bank_o    (bank_c)
  );

  prg_xfer_stage #(.W(PKT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({bank_c, in_addr[OFS_W-1:0]}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pkt_out)
  );

  assign out_bank   = pkt_out[PKT_W-1:OFS_W];
  assign out_offset = pkt_out[OFS_W-1:0];
  assign taken      = in_valid && in_ready;

  AST_WHOLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cfg_ctrl[2] |=> out_bank[1:0] == $past(in_addr[WIN_W-1:OFS_W])); // R2

  AST_HALF_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cfg_ctrl[2:0] == 3'd3 |=> out_bank[0] == $past(in_addr[OFS_W])); // R3

  AST_BASE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cfg_ctrl[2:0] == 3'd3 |=> out_bank[BANK_W-1:1] ==
      $past({cfg_outer_hi[5], cfg_outer_hi[7:6], cfg_ctrl[7], cfg_ctrl[3], cfg_outer_lo[6:0]})); // R1

  AST_FIXED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !cfg_ctrl[2] && cfg_ctrl[1:0] != 2'd3 && !ext_en &&
    in_addr[WIN_W-1:OFS_W] == 2'b11 |=> out_bank[3:0] == 4'hF); // R4

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> out_offset == $past(in_addr[OFS_W-1:0])); // R8

endmodule

// File: tb/sim_prg_bank_mapper.sv
`timescale 1ns/1ps
module sim_prg_bank_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_ctrl = '0, cfg_outer_lo = '0, cfg_outer_hi = '0;
  logic [7:0]  inner_a = '0, inner_b = '0, inner_c = '0, inner_d = '0;
  logic        swap_en = 1'b0, ext_en = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [14:0] in_addr = '0;
  logic        in_ready, out_valid;
  logic [12:0] out_bank, out_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  bit    exp_valid = 1'b0;
  int    exp_bank = 0;
  int    exp_off = 0;
  string exp_tag = "R4";

  always #10 clk = ~clk;

  prg_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_outer_lo(cfg_outer_lo),
    .cfg_outer_hi(cfg_outer_hi), .inner_a(inner_a), .inner_b(inner_b),
    .inner_c(inner_c), .inner_d(inner_d), .swap_en(swap_en), .ext_en(ext_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_bank(out_bank),
    .out_offset(out_offset)
  );

  function automatic int base_of(int c, int lo, int hi);
    return (lo & 'h7F) | ((c << 4) & 'h80) | ((c << 1) & 'h100) |
           ((hi << 3) & 'h600) | ((hi << 6) & 'h800);
  endfunction

  function automatic int model_bank();
    int b, m, s, ob, ls, v, msk;
    b = base_of(cfg_ctrl, cfg_outer_lo, cfg_outer_hi);
    m = cfg_ctrl & 7;
    s = (in_addr >> 13) & 3;
    if (m >= 4) return (b >> 1) * 4 + s;
    if (m == 3) return b * 2 + (s & 1);
    ob = b * 2;
    ls = (swap_en && (s == 0 || s == 2)) ? (s ^ 2) : s;
    case (ls)
      0: v = inner_a;
      1: v = inner_b;
      2: v = ext_en ? int'(inner_c) : 254;
      default: v = ext_en ? int'(inner_d) : 255;
    endcase
    if (ext_en) return v | ob;
    msk = 63 >> m;
    return (v & msk) | (ob & ~msk & 'h1FFF);
  endfunction

  function automatic string model_tag();
    int m;
    m = cfg_ctrl & 7;
    if (m >= 3 && (swap_en || ext_en)) return "R7";
    if (m >= 4) return "R2";
    if (m == 3) return "R3";
    if (ext_en) return "R6";
    if (swap_en) return "R5";
    return "R4";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock: model update at the edge, compare at the falling edge.
  task automatic tick();
    bit rdy;
    @(posedge clk);
    rdy = !exp_valid || out_ready;
    if (!rst_n) begin
      exp_valid = 1'b0;
    end else if (rdy) begin
      exp_valid = in_valid;
      if (in_valid) begin
        exp_bank = model_bank();
        exp_off  = in_addr & 'h1FFF;
        exp_tag  = model_tag();
      end
    end
    @(negedge clk);
    if (!rst_n) check("R10", int'(out_valid), 0);
    else        check("R9", int'(out_valid), int'(exp_valid));
    check("R9", int'(in_ready), int'(!exp_valid || out_ready));
    if (exp_valid && rst_n) begin
      check(exp_tag, int'(out_bank), exp_bank);
      check("R8", int'(out_offset), exp_off);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // Reset state (R10)
    repeat (3) tick();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R10", int'(out_valid), 0);

    // R1: every scattered base bit set, layout 3, read back base from bank
    cfg_ctrl = 8'h8B; cfg_outer_lo = 8'h55; cfg_outer_hi = 8'hE0;
    in_addr = 15'h4123; in_valid = 1'b1; out_ready = 1'b1;
    tick();
    check("R1", int'(out_bank >> 1), 'hFD5);
    check("R3", int'(out_bank & 1), 0);
    // R3: address bit 14 ignored
    in_addr = 15'h0123;
    tick();
    check("R3", int'(out_bank >> 1), 'hFD5);

    // Sweep every layout code, slot, swap and extended setting
    inner_a = 8'hA5; inner_b = 8'h3C; inner_c = 8'h81; inner_d = 8'h6E;
    cfg_outer_lo = 8'h2A; cfg_outer_hi = 8'hA0;
    for (int m = 0; m < 8; m++) begin
      for (int sw = 0; sw < 2; sw++) begin
        for (int ex = 0; ex < 2; ex++) begin
          for (int s = 0; s < 4; s++) begin
            cfg_ctrl = 8'(8'h88 | m);
            swap_en = sw[0]; ext_en = ex[0];
            in_addr = 15'((s << 13) | (m * 97 + s));
            tick();
          end
        end
      end
    end

    // R9: stall with changing inputs, then drain
    in_valid = 1'b1; out_ready = 1'b0;
    for (int k = 0; k < 6; k++) begin
      in_addr = 15'($urandom);
      cfg_ctrl = 8'($urandom);
      tick();
    end
    out_ready = 1'b1;
    in_valid = 1'b0;
    tick();
    tick();
    check("R9", int'(out_valid), 0);

    // Random traffic with back-pressure
    for (int k = 0; k < 4000; k++) begin
      cfg_ctrl = 8'($urandom); cfg_outer_lo = 8'($urandom); cfg_outer_hi = 8'($urandom);
      inner_a = 8'($urandom); inner_b = 8'($urandom);
      inner_c = 8'($urandom); inner_d = 8'($urandom);
      swap_en = 1'($urandom); ext_en = 1'($urandom);
      in_addr = 15'($urandom);
      in_valid = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      tick();
    end

    // Reset during traffic returns to empty (R10)
    in_valid = 1'b1;
    rst_n = 1'b0;
    tick();
    check("R10", int'(out_valid), 0);
    finish_run();
  end

endmodule